// File: doc/BRIEF.md
# Standby DRAM Refresh Supervisor

This block keeps DRAM contents alive while the rest of the system sleeps. A standby request takes it into a low-power state. From then on it paces refresh from a slow 32 kHz tick, which reaches it as a one-clock enable pulse in the fast clock domain. Each refresh is a CAS-before-RAS cycle, so no row address is needed. During standby the address bus is held at all ones and every memory strobe stays actively driven, never floated.

Two safety paths can end standby on their own. The first is a watchdog. If no refresh cycle completes for fifteen refresh periods at the selected rate, it clears standby completely. The second is an interlock. While the external real-time-clock option is on, the slow tick source is gone, so standby is refused, or dropped if it is already active. An inhibit input holds off new refresh cycles; the bench uses it to force a stall.

A small configuration register (memory configuration field plus relocation enable) is kept intact across the standby period.

Top module: `stby_refresh_sup`

## Requirements
- R1: After reset, stby_active, mem_drive_en, refresh_done and cfg_q/reloc_q are 0, ras_n, cas_n and mwe_n are 1, and ma is 0.
- R2: A 0-to-1 change of stby_req while ext_rtc_en is low sets stby_active in the next clock. While stby_active is 1, ma is all ones and mem_drive_en is 1.
- R3: While ext_rtc_en is 1 a rising stby_req does not enter standby. A later fall of ext_rtc_en does not enter standby either; a fresh rise of stby_req is needed. If ext_rtc_en rises during standby, standby ends.
- R4: Each refresh cycle lasts four ticks. cas_n falls on the first tick, ras_n falls on the second, ras_n rises on the fourth while cas_n stays low, and cas_n rises on the tick after that. mwe_n is always 1.
- R5: rate_sel codes 0, 1, 2, 3 give an idle gap of 1, 2, 4, 8 ticks. The gap runs from standby entry, or from the tick that ends a cycle, to the tick that starts the next cycle.
- R6: refresh_done is a single-clock pulse in the clock after the tick that ends each refresh cycle.
- R7: If no refresh completes within 15*(gap+4) ticks of entry or of the last completion, standby ends. It does not resume until stby_req falls and rises again.
- R8: On any exit from standby, ras_n and cas_n are both 1 for one clock while stby_active is still 1. stby_active and mem_drive_en then drop, and ma returns to 0. A fall of stby_req ends standby.
- R9: cfg_we loads cfg_d/reloc_d into cfg_q/reloc_q in the next clock only while stby_active is 0. Writes during standby are ignored, and the values survive standby unchanged.
- R10: While ref_inhibit is 1 no new refresh cycle starts, but a cycle already under way completes. Once ref_inhibit is 0 again, a cycle starts on the first tick, provided the gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_req | input | 1 | Standby request level; its rising edge enters standby |
| ext_rtc_en | input | 1 | External clock option on; slow tick unavailable |
| ref_inhibit | input | 1 | Holds off the start of new refresh cycles |
| rate_sel | input | 2 | Refresh gap code (1, 2, 4, 8 ticks) |
| tick_32k | input | 1 | One-clock pulse per 32 kHz period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_d | input | CFG_W | Memory configuration write data |
| reloc_d | input | 1 | Relocation enable write data |
| cfg_q | output | CFG_W | Retained memory configuration |
| reloc_q | output | 1 | Retained relocation enable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| mwe_n | output | 1 | Write enable, active low, held high |
| ma | output | MA_W | Memory address, all ones in standby |
| mem_drive_en | output | 1 | Memory outputs actively driven |
| refresh_done | output | 1 | Pulse on completion of a refresh cycle |
| stby_active | output | 1 | Standby in force |

## Verification
The bench aims at the exit path. Standby is dropped in the middle of a cycle, with both strobes low. A design that released the strobes together with the active flag, or one that dropped the active flag first, would show a strobe still low in the clock where standby ends.

The watchdog is run to exactly its limit with the inhibit held. The tick before the limit must leave standby intact, and the limit tick must end it. An off-by-one counter, or a design that rearms on the still-high request, would miss the exact boundary or re-enter standby.

The bench also raises the inhibit in the middle of a cycle, where a careless design would abort the cycle. It releases ext_rtc_en with the request already high, where a level-sensitive entry would wrongly start standby. Each gap code is counted tick by tick, and a swapped or shifted rate decode would start the CAS fall on the wrong tick.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int RATE_W    = 2;
  localparam int CBR_TICKS = 4;
  localparam int MAX_GAP   = 1 << ((1 << RATE_W) - 1);

  typedef enum logic [1:0] {
    CTL_OFF  = 2'd0,
    CTL_ON   = 2'd1,
    CTL_EXIT = 2'd2
  } ctl_e;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_CAS    = 3'd1,
    SQ_BOTH_A = 3'd2,
    SQ_BOTH_B = 3'd3,
    SQ_RREL   = 3'd4
  } sq_e;
endpackage

// File: rtl/stby_ctl.sv
module stby_ctl
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ext_rtc,
  input  logic trip,
  output ctl_e state,
  output logic leave
);
  logic req_q;
  logic enter;

  assign enter = req && !req_q && !ext_rtc;
  assign leave = (state == CTL_ON) && (!req || ext_rtc || trip);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CTL_OFF;
      req_q <= 1'b0;
    end else begin
      req_q <= req;
      unique case (state)
        CTL_OFF:  if (enter) state <= CTL_ON;
        CTL_ON:   if (leave) state <= CTL_EXIT;
        CTL_EXIT: state <= CTL_OFF;
        default:  state <= CTL_OFF;
      endcase
    end
  end

  // R3: slow clock missing keeps standby off
  assert_rtc_refuse_R3: assert property (@(posedge clk) disable iff (rst)
    (state == CTL_OFF && ext_rtc) |=> state == CTL_OFF);

  // R7: a watchdog trip ends standby
  assert_trip_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state == CTL_ON && trip) |=> state == CTL_EXIT);

  // R8: the exit state lasts exactly one clock
  assert_exit_once_R8: assert property (@(posedge clk) disable iff (rst)
    (state == CTL_EXIT) |=> state == CTL_OFF);
endmodule

// File: rtl/stby_cbr_seq.sv
module stby_cbr_seq
  import stby_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              inhibit,
  input  logic [RATE_W-1:0] rate,
  output logic              ras_n,
  output logic              cas_n,
  output logic              done
);
  localparam int GAP_W = $clog2(MAX_GAP + 1);

  sq_e             st_q, st_d;
  logic [GAP_W-1:0] gap_q, gap_d, gap_len;
  logic            fin;

  assign gap_len = GAP_W'(1) << rate;

  always_comb begin
    st_d  = st_q;
    gap_d = gap_q;
    fin   = 1'b0;
    if (!run) begin
      st_d  = SQ_IDLE;
      gap_d = '0;
    end else if (tick) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (gap_q + GAP_W'(1) >= gap_len) begin
            if (!inhibit) begin
              st_d  = SQ_CAS;
              gap_d = '0;
            end else begin
              gap_d = gap_len - GAP_W'(1);
            end
          end else begin
            gap_d = gap_q + GAP_W'(1);
          end
        end
        SQ_CAS:    st_d = SQ_BOTH_A;
        SQ_BOTH_A: st_d = SQ_BOTH_B;
        SQ_BOTH_B: st_d = SQ_RREL;
        SQ_RREL: begin
          st_d  = SQ_IDLE;
          gap_d = '0;
          fin   = 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      gap_q <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
      ras_n <= !(st_d == SQ_BOTH_A || st_d == SQ_BOTH_B);
      cas_n <= !(st_d inside {SQ_CAS, SQ_BOTH_A, SQ_BOTH_B, SQ_RREL});
      done  <= fin;
    end
  end

  // R4: row strobe is only ever low under a low column strobe
  assert_ras_under_cas_R4: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);

  // R4: column strobe leads the row strobe
  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(!cas_n));

  // R6: completion marker is one clock wide
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/stby_refresh_wd.sv
module stby_refresh_wd
  import stby_pkg::*;
#(
  parameter int PERIODS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              tick,
  input  logic              done,
  input  logic [RATE_W-1:0] rate,
  output logic              trip
);
  localparam int MAX_LIMIT = PERIODS * (MAX_GAP + CBR_TICKS);
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(PERIODS * ((1 << rate) + CBR_TICKS));
  assign trip  = arm && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !arm || done) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < limit)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R7: count moves only on a slow tick
  assert_wd_step_R7: assert property (@(posedge clk) disable iff (rst)
    (arm && $past(arm) && !$past(done) && !$past(tick)) |-> $stable(cnt_q));
endmodule

// File: rtl/stby_refresh_sup.sv
module stby_refresh_sup
  import stby_pkg::*;
#(
  parameter int MA_W       = 10,
  parameter int CFG_W      = 4,
  parameter int WD_PERIODS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby_req,
  input  logic              ext_rtc_en,
  input  logic              ref_inhibit,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              tick_32k,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_d,
  input  logic              reloc_d,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              reloc_q,
  output logic              ras_n,
  output logic              cas_n,
  output logic              mwe_n,
  output logic [MA_W-1:0]   ma,
  output logic              mem_drive_en,
  output logic              refresh_done,
  output logic              stby_active
);
  ctl_e ctl;
  logic leave;
  logic trip;
  logic run;

  stby_ctl ctl_i (
    .clk     (clk),
    .rst     (rst),
    .req     (stby_req),
    .ext_rtc (ext_rtc_en),
    .trip    (trip),
    .state   (ctl),
    .leave   (leave)
  );

  assign run = (ctl == CTL_ON) && !leave;

  stby_cbr_seq seq_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .tick    (tick_32k),
    .inhibit (ref_inhibit),
    .rate    (rate_sel),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .done    (refresh_done)
  );

  stby_refresh_wd #(.PERIODS(WD_PERIODS)) wd_i (
    .clk  (clk),
    .rst  (rst),
    .arm  (ctl == CTL_ON),
    .tick (tick_32k),
    .done (refresh_done),
    .rate (rate_sel),
    .trip (trip)
  );

  assign stby_active  = (ctl != CTL_OFF);
  assign mem_drive_en = stby_active;
  assign ma           = {MA_W{stby_active}};
  assign mwe_n        = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      reloc_q <= 1'b0;
    end else if (cfg_we && !stby_active) begin
      cfg_q   <= cfg_d;
      reloc_q <= reloc_d;
    end
  end

  // R8: strobes are released before standby is dropped
  assert_strobes_first_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(stby_active) |-> $past(ras_n && cas_n));

  // R9: retained configuration is frozen during standby
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    stby_active |=> $stable({cfg_q, reloc_q}));

  // R8: no strobe low outside standby
  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    !stby_active |-> (ras_n && cas_n));
endmodule

// File: tb/stby_refresh_sup_tb_top.sv
`timescale 1ns/1ps
module stby_refresh_sup_tb_top;
  localparam int MA_W  = 10;
  localparam int CFG_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stby_req = 1'b0, ext_rtc_en = 1'b0, ref_inhibit = 1'b0;
  logic [1:0]       rate_sel = 2'd0;
  logic             tick_32k = 1'b0, cfg_we = 1'b0, reloc_d = 1'b0;
  logic [CFG_W-1:0] cfg_d = '0;
  logic [CFG_W-1:0] cfg_q;
  logic             reloc_q, ras_n, cas_n, mwe_n, mem_drive_en, refresh_done, stby_active;
  logic [MA_W-1:0]  ma;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  stby_refresh_sup #(.MA_W(MA_W), .CFG_W(CFG_W)) dut_i (
    .clk(clk), .rst(rst), .stby_req(stby_req), .ext_rtc_en(ext_rtc_en),
    .ref_inhibit(ref_inhibit), .rate_sel(rate_sel), .tick_32k(tick_32k),
    .cfg_we(cfg_we), .cfg_d(cfg_d), .reloc_d(reloc_d), .cfg_q(cfg_q),
    .reloc_q(reloc_q), .ras_n(ras_n), .cas_n(cas_n), .mwe_n(mwe_n), .ma(ma),
    .mem_drive_en(mem_drive_en), .refresh_done(refresh_done),
    .stby_active(stby_active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // phase of tick k within the refresh pattern for gap n; 99 = not yet started
  function automatic int phase(input int k, input int n);
    if (k < n) return 99;
    return (k - n) % (n + 4);
  endfunction

  task automatic pulse_tick();
    tick_32k = 1'b1;
    step(1);
    tick_32k = 1'b0;
  endtask

  task automatic tick_chk(input int k, input int n);
    int q;
    q = phase(k, n);
    pulse_tick();
    check("R5 cas_n tick pattern", cas_n, (q <= 3) ? 0 : 1);
    check("R4 ras_n tick pattern", ras_n, (q == 1 || q == 2) ? 0 : 1);
    check("R6 refresh_done pulse", refresh_done, (q == 4) ? 1 : 0);
    check("R4 mwe_n high", mwe_n, 1);
    step(1);
    check("R6 refresh_done width", refresh_done, 0);
    step(1);
  endtask

  task automatic enter(input logic [1:0] r);
    rate_sel = r;
    stby_req = 1'b0;
    step(1);
    stby_req = 1'b1;
    step(1);
    check("R2 active on rise", stby_active, 1);
    check("R2 ma all ones", ma, {MA_W{1'b1}});
    check("R2 drive enable", mem_drive_en, 1);
  endtask

  task automatic leave_chk();
    stby_req = 1'b0;
    step(1);
    check("R8 active held in exit", stby_active, 1);
    check("R8 strobes high in exit", {ras_n, cas_n}, 2'b11);
    step(1);
    check("R8 active dropped", stby_active, 0);
    check("R8 ma released", ma, 0);
    check("R8 drive released", mem_drive_en, 0);
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] d, input logic rl);
    cfg_d   = d;
    reloc_d = rl;
    cfg_we  = 1'b1;
    step(1);
    cfg_we  = 1'b0;
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [CFG_W-1:0] keep;
    logic             keep_rl;
    int               n, nt;
    void'($urandom(32'd4242));

    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 active", stby_active, 0);
    check("R1 strobes", {ras_n, cas_n, mwe_n}, 3'b111);
    check("R1 ma", ma, 0);
    check("R1 drive/done", {mem_drive_en, refresh_done}, 2'b00);
    check("R1 cfg", {cfg_q, reloc_q}, 0);

    // R9 write while idle
    write_cfg(4'hA, 1'b1);
    check("R9 idle write", {cfg_q, reloc_q}, {4'hA, 1'b1});

    // R5 every rate code, two full cycles each
    for (int r = 0; r < 4; r++) begin
      n = 1 << r;
      enter(2'(r));
      for (int k = 1; k <= 2 * (n + 4) + 1; k++) tick_chk(k, n);
      leave_chk();
    end

    // R8 exit in mid cycle with both strobes low
    enter(2'd2);
    for (int k = 1; k <= 5; k++) tick_chk(k, 4);
    check("R8 both low before exit", {ras_n, cas_n}, 2'b00);
    leave_chk();

    // R9 writes during standby ignored, value kept
    enter(2'd0);
    write_cfg(4'h5, 1'b0);
    check("R9 standby write ignored", {cfg_q, reloc_q}, {4'hA, 1'b1});
    leave_chk();
    check("R9 retained after standby", {cfg_q, reloc_q}, {4'hA, 1'b1});

    // R3 interlock refuses entry, and no entry on its release
    ext_rtc_en = 1'b1;
    step(1);
    stby_req = 1'b1;
    step(2);
    check("R3 entry refused", stby_active, 0);
    ext_rtc_en = 1'b0;
    step(2);
    check("R3 no entry on release", stby_active, 0);
    // R3 interlock forces exit
    enter(2'd0);
    for (int k = 1; k <= 3; k++) tick_chk(k, 1);
    ext_rtc_en = 1'b1;
    step(1);
    check("R3 exit strobes high", {stby_active, ras_n, cas_n}, 3'b111);
    step(1);
    check("R3 forced off", stby_active, 0);
    ext_rtc_en = 1'b0;
    stby_req   = 1'b0;
    step(2);

    // R10 inhibit mid cycle: cycle completes, next start held
    enter(2'd1);
    for (int k = 1; k <= 2; k++) tick_chk(k, 2);
    ref_inhibit = 1'b1;
    for (int k = 3; k <= 6; k++) tick_chk(k, 2);
    for (int k = 7; k <= 10; k++) begin
      pulse_tick();
      check("R10 no start while inhibited", cas_n, 1);
      step(2);
    end
    ref_inhibit = 1'b0;
    pulse_tick();
    check("R10 start after release", cas_n, 0);
    step(2);
    leave_chk();

    // R7 watchdog boundary at gap 1: limit 75 ticks
    ref_inhibit = 1'b1;
    enter(2'd0);
    for (int k = 1; k <= 74; k++) begin
      pulse_tick();
      step(2);
    end
    check("R7 alive before limit", stby_active, 1);
    pulse_tick();
    step(2);
    check("R7 cleared at limit", stby_active, 0);
    check("R7 strobes idle", {ras_n, cas_n}, 2'b11);
    for (int k = 0; k < 3; k++) begin
      pulse_tick();
      step(2);
    end
    check("R7 no rearm on held request", stby_active, 0);
    ref_inhibit = 1'b0;
    // R7 no false trip with healthy refresh, 100 ticks
    enter(2'd0);
    for (int k = 1; k <= 100; k++) tick_chk(k, 1);
    check("R7 healthy refresh stays", stby_active, 1);
    leave_chk();

    // random trials
    for (int t = 0; t < 12; t++) begin
      logic [1:0] r;
      r    = 2'($urandom % 4);
      n    = 1 << r;
      nt   = 12 + int'($urandom % 40);
      keep = 4'($urandom);
      keep_rl = 1'($urandom);
      write_cfg(keep, keep_rl);
      check("R9 random idle write", {cfg_q, reloc_q}, {keep, keep_rl});
      enter(r);
      for (int k = 1; k <= nt; k++) begin
        tick_chk(k, n);
        if (k == nt / 2) begin
          write_cfg(4'($urandom), 1'($urandom));
          check("R9 random write ignored", {cfg_q, reloc_q}, {keep, keep_rl});
        end
      end
      leave_chk();
      check("R9 random retained", {cfg_q, reloc_q}, {keep, keep_rl});
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule